// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises a processor that must prove it is alive by pulsing a restart strobe (a "kick") at the right moment, not merely often enough. After every restart the block first runs a closed span, in which a kick is premature, and then an open span, in which a kick is accepted. An accepted kick starts a new closed span. If the open span runs out with no kick, a sticky timeout flag is raised for the corrective-action logic downstream. A kick that arrives during the closed span does not restart anything. Depending on a build parameter it either raises a sticky early-kick fault or is dropped without effect.

Both span lengths come from configuration inputs. They are captured only when a span pair is started, so software may change them at any time and the change applies from the next restart. Supervision starts in one of two ways. The block can follow an enable input. It can also start by itself once a fixed boot hold-off has run out after reset, which gives the system time to boot before kicks are expected.

Top module: `win_watchdog`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `timeout`, `early_fault` and `win_open` are all low.
- R2: While supervision is inactive (`AUTO_START`=0 and `en` low), all three outputs stay low and kicks have no effect. When `en` is sampled low on an edge, all flags clear after that edge.
- R3: Supervision starts at the first edge where it is active. From that edge, or from an accepted kick, `win_open` is low for max(`open_dly`,1) cycles. It is then high for max(`close_dly`,1) cycles.
- R4: A kick sampled while `win_open` is high is accepted. In the next cycle `win_open` is low and a new closed span of max(`open_dly`,1) cycles begins.
- R5: A kick in the last open cycle, where the window would otherwise close, is accepted like any other kick inside the window.
- R6: If the open span ends with no kick, `timeout` rises in the next cycle and `win_open` stays low. `timeout` holds until reset or until supervision goes inactive. Kicks after that point change nothing, and they do not set `early_fault`.
- R7: With `EARLY_FAULT_EN`=1, a kick during the closed span sets `early_fault` in the next cycle. The flag is sticky. The kick does not move the window schedule.
- R8: With `EARLY_FAULT_EN`=0, a kick during the closed span does not set `early_fault` and does not move the window schedule.
- R9: `open_dly` and `close_dly` are captured only at the start edge and at accepted kicks. Changes at any other time act only from the next restart.
- R10: With `AUTO_START`=1, `en` is ignored. Supervision becomes active `BOOT_HOLD` cycles after reset is released. The window first opens on edge number `BOOT_HOLD`+max(`open_dly`,1)+1 after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Supervision enable (used when AUTO_START=0) |
| kick | input | 1 | Restart strobe, sampled each edge |
| open_dly | input | CNT_W | Closed-span length in cycles (0 acts as 1) |
| close_dly | input | CNT_W | Open-span length in cycles (0 acts as 1) |
| timeout | output | 1 | Sticky: window ended without a kick |
| early_fault | output | 1 | Sticky: kick arrived before the window opened |
| win_open | output | 1 | High while a kick would be accepted |

## Verification
The bound properties assume that reset is high from time zero and that `kick` and `en` are synchronous to `clk`. They place no limit on how long a kick pulse lasts or on when the delay inputs change. The bench drives every input on the falling edge and samples the outputs there too, one cycle after the edge under test. It changes the delay inputs in the middle of a span on purpose, to check the capture rule. Kicks are placed in the first open cycle, in the last open cycle, in the closed span and after a timeout. A second instance covers the self-starting build with a boot hold-off and dropped early kicks.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // not supervising, counters track their load values
    PH_SHUT = 2'd1,  // closed span: kicks are premature
    PH_OPEN = 2'd2,  // open span: kicks accepted
    PH_DEAD = 2'd3   // open span expired, timeout held
  } wwd_phase_e;
endpackage

// File: rtl/wwd_boot_gate.sv
module wwd_boot_gate #(
  parameter int BOOT_HOLD  = 4,
  parameter bit AUTO_START = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic active
);
  localparam int BW = (BOOT_HOLD > 0) ? $clog2(BOOT_HOLD + 1) : 1;

  logic [BW-1:0] hold_cnt;
  logic          boot_done;

  always_ff @(posedge clk) begin
    if (rst) hold_cnt <= '0;
    else if (hold_cnt < BW'(BOOT_HOLD)) hold_cnt <= hold_cnt + 1'b1;
  end

  assign boot_done = (hold_cnt == BW'(BOOT_HOLD));

  generate
    if (AUTO_START) begin : g_self
      logic en_unused;
      assign en_unused = en;
      assign active = boot_done;
    end else begin : g_pin
      assign active = boot_done & en;
    end
  endgenerate
endmodule

// File: rtl/wwd_span_ctr.sv
module wwd_span_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)                    left <= '0;
    else if (load)              left <= load_val;
    else if (dec && left != '0) left <= left - 1'b1;
  end

  // final cycle of a span; a zero load behaves as a one-cycle span
  assign last = (left <= W'(1));
endmodule

// File: rtl/wwd_phase_fsm.sv
module wwd_phase_fsm
  import wwd_pkg::*;
#(
  parameter bit EARLY_FAULT_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic       kick,
  input  logic       shut_last,
  input  logic       open_last,
  output wwd_phase_e phase,
  output logic       ctr_load,
  output logic       shut_dec,
  output logic       open_dec,
  output logic       early_fault
);
  wwd_phase_e nxt;
  logic       restart;
  logic       early_hit;

  always_comb begin
    nxt     = phase;
    restart = 1'b0;
    unique case (phase)
      PH_IDLE: if (active) nxt = PH_SHUT;
      PH_SHUT: begin
        if (!active)        nxt = PH_IDLE;
        else if (shut_last) nxt = PH_OPEN;
      end
      PH_OPEN: begin
        if (!active) nxt = PH_IDLE;
        else if (kick) begin
          nxt     = PH_SHUT;
          restart = 1'b1;
        end else if (open_last) nxt = PH_DEAD;
      end
      PH_DEAD: if (!active) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  generate
    if (EARLY_FAULT_EN) begin : g_flag
      assign early_hit = active && kick && (phase == PH_SHUT);
    end else begin : g_drop
      assign early_hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      early_fault <= 1'b0;
    end else begin
      phase <= nxt;
      if (!active)        early_fault <= 1'b0;
      else if (early_hit) early_fault <= 1'b1;
    end
  end

  assign ctr_load = (phase == PH_IDLE) || restart;
  assign shut_dec = (phase == PH_SHUT);
  assign open_dec = (phase == PH_OPEN);
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwd_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter int BOOT_HOLD      = 4,
  parameter bit AUTO_START     = 1'b0,
  parameter bit EARLY_FAULT_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             kick,
  input  logic [CNT_W-1:0] open_dly,
  input  logic [CNT_W-1:0] close_dly,
  output logic             timeout,
  output logic             early_fault,
  output logic             win_open
);
  localparam int NSPAN = 2;  // index 0: closed span, 1: open span

  logic                       active;
  wwd_phase_e                 phase;
  logic                       ctr_load;
  logic [NSPAN-1:0]           span_dec;
  logic [NSPAN-1:0]           span_last;
  logic [NSPAN-1:0][CNT_W-1:0] span_val;

  assign span_val[0] = open_dly;
  assign span_val[1] = close_dly;

  wwd_boot_gate #(.BOOT_HOLD(BOOT_HOLD), .AUTO_START(AUTO_START)) u_gate (
    .clk(clk), .rst(rst), .en(en), .active(active)
  );

  for (genvar g = 0; g < NSPAN; g++) begin : g_span
    wwd_span_ctr #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst(rst), .load(ctr_load), .load_val(span_val[g]),
      .dec(span_dec[g]), .last(span_last[g])
    );
  end

  wwd_phase_fsm #(.EARLY_FAULT_EN(EARLY_FAULT_EN)) u_fsm (
    .clk(clk), .rst(rst), .active(active), .kick(kick),
    .shut_last(span_last[0]), .open_last(span_last[1]),
    .phase(phase), .ctr_load(ctr_load),
    .shut_dec(span_dec[0]), .open_dec(span_dec[1]),
    .early_fault(early_fault)
  );

  assign timeout  = (phase == PH_DEAD);
  assign win_open = (phase == PH_OPEN);
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker (
  input logic clk,
  input logic rst,
  input logic active,
  input logic kick,
  input logic timeout,
  input logic early_fault,
  input logic win_open
);
  // R6
  timeout_not_open_chk: assert property (@(posedge clk) disable iff (rst)
    !(timeout && win_open));

  // R6
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    timeout && active |=> timeout);

  // R2
  idle_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> !timeout && !early_fault && !win_open);

  // R4
  kick_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    win_open && kick && active |=> !win_open && !timeout);

  // R7
  early_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    early_fault && active |=> early_fault);

  // R7
  early_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(early_fault) |-> $past(kick) && !$past(win_open));

  // R6
  timeout_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> $past(win_open) && !$past(kick));
endmodule

bind win_watchdog wwd_checker u_wwd_chk (
  .clk(clk), .rst(rst), .active(active), .kick(kick),
  .timeout(timeout), .early_fault(early_fault), .win_open(win_open)
);

// File: tb/tb_win_watchdog.sv
`timescale 1ns/1ps
module tb_win_watchdog;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, kick = 1'b0, kick_a = 1'b0;
  logic [W-1:0] odly = 3, cdly = 4;
  logic to_m, ef_m, wo_m, to_a, ef_a, wo_a;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  win_watchdog #(.CNT_W(W), .BOOT_HOLD(0), .AUTO_START(1'b0), .EARLY_FAULT_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .en(en), .kick(kick), .open_dly(odly), .close_dly(cdly),
    .timeout(to_m), .early_fault(ef_m), .win_open(wo_m)
  );

  win_watchdog #(.CNT_W(W), .BOOT_HOLD(6), .AUTO_START(1'b1), .EARLY_FAULT_EN(1'b0)) dut_auto (
    .clk(clk), .rst(rst), .en(1'b0), .kick(kick_a), .open_dly(W'(3)), .close_dly(W'(4)),
    .timeout(to_a), .early_fault(ef_a), .win_open(wo_a)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) step();
    rst = 1'b0;
    check("R1 timeout", to_m, 1'b0);
    check("R1 early_fault", ef_m, 1'b0);
    check("R1 win_open", wo_m, 1'b0);
  endtask

  // self-starting instance: boot hold 6, closed span 3, open span 4
  task automatic t_auto_boot();
    for (int i = 1; i <= 9; i++) begin
      step();
      check("R10 window closed during hold and closed span", wo_a, 1'b0);
      kick_a = (i == 7);  // premature kick in the closed span
    end
    step();
    check("R10 window opens at edge hold+open+1", wo_a, 1'b1);
    check("R8 early kick not flagged", ef_a, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R8 schedule unaffected by early kick", wo_a, 1'b1);
    end
    step();
    check("R10 timeout after open span", to_a, 1'b1);
  endtask

  task automatic t_disabled();
    for (int i = 0; i < 8; i++) begin
      kick = i[0];
      step();
      check("R2 win_open idle", wo_m, 1'b0);
      check("R2 timeout idle", to_m, 1'b0);
      check("R2 early_fault idle", ef_m, 1'b0);
    end
    kick = 1'b0;
  endtask

  task automatic t_timing_and_timeout();
    odly = 3; cdly = 4; en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R3 closed span", wo_m, 1'b0);
    end
    for (int i = 0; i < 4; i++) begin
      step();
      check("R3 open span", wo_m, 1'b1);
    end
    step();
    check("R6 timeout raised", to_m, 1'b1);
    check("R6 window shut after timeout", wo_m, 1'b0);
    for (int i = 0; i < 6; i++) begin
      kick = ~i[0];
      step();
      check("R6 timeout sticky under kicks", to_m, 1'b1);
      check("R6 late kick not early", ef_m, 1'b0);
    end
    kick = 1'b0; en = 1'b0;
    step();
    check("R2 disable clears timeout", to_m, 1'b0);
  endtask

  task automatic t_kicks();
    en = 1'b1;
    repeat (3) step();
    step();
    check("R4 window open before kick", wo_m, 1'b1);
    kick = 1'b1; step(); kick = 1'b0;
    check("R4 accepted kick closes window", wo_m, 1'b0);
    check("R4 no timeout", to_m, 1'b0);
    repeat (2) step();
    check("R4 closed span restarted", wo_m, 1'b0);
    step();
    check("R4 window reopens", wo_m, 1'b1);
    repeat (3) step();
    check("R5 last open cycle", wo_m, 1'b1);
    kick = 1'b1; step(); kick = 1'b0;
    check("R5 closing-cycle kick accepted", wo_m, 1'b0);
    check("R5 no timeout", to_m, 1'b0);
    repeat (2) step();
    step();
    check("R5 window reopens", wo_m, 1'b1);
    en = 1'b0; step();
  endtask

  task automatic t_early();
    en = 1'b1;
    step();
    kick = 1'b1; step(); kick = 1'b0;
    check("R7 early fault set", ef_m, 1'b1);
    check("R7 still closed", wo_m, 1'b0);
    step();
    check("R7 schedule kept", wo_m, 1'b0);
    step();
    check("R7 opens on schedule", wo_m, 1'b1);
    repeat (3) step();
    step();
    check("R7 no restart from early kick", to_m, 1'b1);
    check("R7 early fault sticky", ef_m, 1'b1);
    en = 1'b0; step();
    check("R2 disable clears early fault", ef_m, 1'b0);
  endtask

  task automatic t_sampling();
    odly = 3; cdly = 4; en = 1'b1;
    step();
    odly = 6; cdly = 2;
    repeat (2) step();
    check("R9 old closed span kept", wo_m, 1'b0);
    step();
    check("R9 opens after old closed span", wo_m, 1'b1);
    repeat (3) step();
    check("R9 old open span kept", wo_m, 1'b1);
    kick = 1'b1; step(); kick = 1'b0;
    for (int i = 0; i < 5; i++) step();
    check("R9 new closed span used", wo_m, 1'b0);
    step();
    check("R9 opens after new closed span", wo_m, 1'b1);
    step();
    check("R9 new open span used", wo_m, 1'b1);
    step();
    check("R9 timeout after new open span", to_m, 1'b1);
    en = 1'b0; step();
  endtask

  initial begin
    t_reset();
    t_auto_boot();
    t_disabled();
    t_timing_and_timeout();
    t_kicks();
    t_early();
    t_sampling();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule